// File: doc/BRIEF.md
# Condition Flag and Status Word Unit

This unit keeps the processor status word: four arithmetic condition flags and a sticky saturation flag in the top bits, the two interrupt mask bits, the instruction-state bit and a five-bit mode field in the low byte. Each cycle it can take one ALU operation: the operation class, both operands, the result, a set-flags request, an indication that the destination is the program counter, a compare-only indication and an optional shifter carry. From these it works out the negative, zero, carry and overflow flags and stores them on the next clock edge.

Software-style direct writes reach the status word through a byte-masked write port. While the mode field holds the user encoding, the low control byte is protected from such writes. Two outputs give the interrupt enables as the inverse of the mask bits.

Top module: `cond_status_unit`

## Requirements
- R1: After reset the status word is 0x000000D3: flags clear, both interrupt mask bits set (bit 7 and bit 6), instruction-state bit 5 clear, mode field bits 4:0 = 0b10011.
- R2: When flags are updated by an add, subtract or logical operation, N (bit 31) takes bit 31 of the result and Z (bit 30) is 1 exactly when the result is zero; the new flags are visible after the clock edge at which the operation is presented.
- R3: For an add (op_class 0), C (bit 29) is the unsigned carry out of a+b and V (bit 28) is 1 on two's-complement signed overflow.
- R4: For a subtract (op_class 1, a-b), C is 0 when a borrow occurs (a < b unsigned) and 1 otherwise; V is 1 on signed overflow of a-b.
- R5: For a logical operation (op_class 2), C takes shift_carry when shift_carry_valid is 1 and otherwise keeps its value; V keeps its value.
- R6: Flags change only when set_flags is 1 and dest_is_pc is 0, except that compare_only=1 updates the flags regardless of set_flags and dest_is_pc. A saturating operation (op_class 3) never changes N, Z, C or V.
- R7: Q (bit 27) is set by a saturating operation with sat_overflow=1, stays set across later operations, and is cleared only by a direct write covering the top byte (wr_mask bit 3).
- R8: irq_enable is the inverse of bit 7 and fiq_enable is the inverse of bit 6.
- R9: A direct write replaces byte k of the status word with byte k of wr_data for each set wr_mask bit k; byte 0 is left unchanged when the current mode field is 0b10000 (user).
- R10: When a direct write and an operation arrive in the same cycle, the write takes effect and the operation's flag and Q updates are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | An ALU operation is presented this cycle |
| op_class | input | 2 | 0 add, 1 subtract, 2 logical, 3 saturating |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand |
| op_res | input | 32 | ALU result |
| set_flags | input | 1 | Operation asks to update the flags |
| dest_is_pc | input | 1 | Destination is the program counter |
| compare_only | input | 1 | Compare-style operation without write-back |
| shift_carry_valid | input | 1 | A shifter carry accompanies a logical operation |
| shift_carry | input | 1 | Shifter carry value |
| sat_overflow | input | 1 | Saturating operation overflowed |
| wr_en | input | 1 | Direct status write |
| wr_mask | input | 4 | Byte enables for the direct write |
| wr_data | input | 32 | Direct write data |
| status_word | output | 32 | Current status word |
| irq_enable | output | 1 | Normal interrupt enabled |
| fiq_enable | output | 1 | Fast interrupt enabled |

## Verification
The hardest state to reach is user mode with live flags, because the unit resets into a privileged mode and only a direct write can enter user mode; once there, the control byte can no longer be changed, so the bench orders its scenarios so that all privileged-mode checks run first and the lock-out checks run last. A write colliding with an operation in the same cycle is driven deliberately with operands whose flags would differ from the written byte, so a wrong priority shows up in the top nibble.

// File: rtl/cond_status_pkg.sv
package cond_status_pkg;

  localparam int unsigned WORD_W = 32;

  typedef enum logic [1:0] {
    OPC_ADD   = 2'd0,
    OPC_SUB   = 2'd1,
    OPC_LOGIC = 2'd2,
    OPC_SAT   = 2'd3
  } op_class_e;

  // Bit positions the rest of the pipeline decodes
  localparam int unsigned BIT_N = 31;
  localparam int unsigned BIT_Z = 30;
  localparam int unsigned BIT_C = 29;
  localparam int unsigned BIT_V = 28;
  localparam int unsigned BIT_Q = 27;
  localparam int unsigned BIT_I = 7;
  localparam int unsigned BIT_F = 6;

  localparam logic [4:0] MODE_USER = 5'b10000;
  localparam logic [4:0] MODE_SUPV = 5'b10011;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } nzcv_t;

  function automatic logic add_carry(input logic [WORD_W-1:0] a,
                                     input logic [WORD_W-1:0] b);
    logic [WORD_W:0] sum;
    sum = {1'b0, a} + {1'b0, b};
    return sum[WORD_W];
  endfunction

  function automatic logic sub_no_borrow(input logic [WORD_W-1:0] a,
                                         input logic [WORD_W-1:0] b);
    return (a >= b);
  endfunction

  function automatic logic add_ovf(input logic [WORD_W-1:0] a,
                                   input logic [WORD_W-1:0] b,
                                   input logic [WORD_W-1:0] r);
    return (a[WORD_W-1] == b[WORD_W-1]) && (r[WORD_W-1] != a[WORD_W-1]);
  endfunction

  function automatic logic sub_ovf(input logic [WORD_W-1:0] a,
                                   input logic [WORD_W-1:0] b,
                                   input logic [WORD_W-1:0] r);
    return (a[WORD_W-1] != b[WORD_W-1]) && (r[WORD_W-1] != a[WORD_W-1]);
  endfunction

endpackage

// File: rtl/flag_calc.sv
module flag_calc
  import cond_status_pkg::*;
#(
  parameter int unsigned W = WORD_W
) (
  input  logic [1:0]   op_class,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [W-1:0] res,
  input  logic         shift_carry_valid,
  input  logic         shift_carry,
  input  nzcv_t        cur,
  output nzcv_t        nxt
);

  always_comb begin
    nxt   = cur;
    nxt.n = res[W-1];
    nxt.z = (res == '0);
    case (op_class)
      OPC_ADD: begin
        nxt.c = add_carry(a, b);
        nxt.v = add_ovf(a, b, res);
      end
      OPC_SUB: begin
        nxt.c = sub_no_borrow(a, b);
        nxt.v = sub_ovf(a, b, res);
      end
      OPC_LOGIC: begin
        nxt.c = shift_carry_valid ? shift_carry : cur.c;
      end
      default: nxt = cur;
    endcase
  end

endmodule

// File: rtl/status_merge.sv
module status_merge
  import cond_status_pkg::*;
#(
  parameter int unsigned W = WORD_W,
  localparam int unsigned NBYTES = W / 8
) (
  input  logic [W-1:0]      cur,
  input  logic [W-1:0]      wdata,
  input  logic [NBYTES-1:0] wmask,
  input  logic              user_mode,
  output logic [W-1:0]      merged,
  output logic              ctrl_blocked
);

  assign ctrl_blocked = user_mode && wmask[0];

  for (genvar k = 0; k < NBYTES; k++) begin : g_byte
    logic take;
    if (k == 0) begin : g_ctrl
      assign take = wmask[k] && !user_mode;
    end else begin : g_plain
      assign take = wmask[k];
    end
    assign merged[k*8 +: 8] = take ? wdata[k*8 +: 8] : cur[k*8 +: 8];
  end

endmodule

// File: rtl/cond_status_unit.sv
module cond_status_unit
  import cond_status_pkg::*;
#(
  parameter int unsigned W          = WORD_W,
  parameter logic [4:0]  RESET_MODE = MODE_SUPV,
  localparam int unsigned NBYTES    = W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic [1:0]        op_class,
  input  logic [W-1:0]      op_a,
  input  logic [W-1:0]      op_b,
  input  logic [W-1:0]      op_res,
  input  logic              set_flags,
  input  logic              dest_is_pc,
  input  logic              compare_only,
  input  logic              shift_carry_valid,
  input  logic              shift_carry,
  input  logic              sat_overflow,
  input  logic              wr_en,
  input  logic [NBYTES-1:0] wr_mask,
  input  logic [W-1:0]      wr_data,
  output logic [W-1:0]      status_word,
  output logic              irq_enable,
  output logic              fiq_enable
);

  localparam logic [W-1:0] RESET_WORD =
    W'((1 << BIT_I) | (1 << BIT_F) | int'(RESET_MODE));

  logic [W-1:0] sw_q;
  nzcv_t        cur_flags;
  nzcv_t        new_flags;
  logic [W-1:0] wr_merged;

  // Named internal events
  logic flag_upd;
  logic q_set;
  logic user_mode;
  logic ctrl_blocked;

  assign cur_flags = nzcv_t'(sw_q[BIT_N:BIT_V]);
  assign user_mode = (sw_q[4:0] == MODE_USER);
  assign flag_upd  = op_valid && !wr_en && (op_class != OPC_SAT) &&
                     (compare_only || (set_flags && !dest_is_pc));
  assign q_set     = op_valid && !wr_en && (op_class == OPC_SAT) && sat_overflow;

  flag_calc #(.W(W)) u_calc (
    .op_class          (op_class),
    .a                 (op_a),
    .b                 (op_b),
    .res               (op_res),
    .shift_carry_valid (shift_carry_valid),
    .shift_carry       (shift_carry),
    .cur               (cur_flags),
    .nxt               (new_flags)
  );

  status_merge #(.W(W)) u_merge (
    .cur          (sw_q),
    .wdata        (wr_data),
    .wmask        (wr_mask),
    .user_mode    (user_mode),
    .merged       (wr_merged),
    .ctrl_blocked (ctrl_blocked)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sw_q <= RESET_WORD;
    end else if (wr_en) begin
      sw_q <= wr_merged;
    end else begin
      if (flag_upd) sw_q[BIT_N:BIT_V] <= new_flags;
      if (q_set)    sw_q[BIT_Q]       <= 1'b1;
    end
  end

  assign status_word = sw_q;
  assign irq_enable  = !sw_q[BIT_I];
  assign fiq_enable  = !sw_q[BIT_F];

  // R6: program-counter destination leaves the flags alone
  p_pc_dest_keeps_flags_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && dest_is_pc && !compare_only && !wr_en) |=> $stable(status_word[BIT_N:BIT_V]));

  // R7: Q is sticky without a direct write
  p_q_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (status_word[BIT_Q] && !wr_en) |=> status_word[BIT_Q]);

  // R9: user mode protects the control byte
  p_user_ctrl_locked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_blocked && wr_en |=> $stable(status_word[7:0]));

  // R2: zero flag follows the result
  p_zero_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
    flag_upd |=> status_word[BIT_Z] == ($past(op_res) == '0));

  // R4: subtract carry is the inverse of borrow
  p_sub_carry_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_upd && op_class == OPC_SUB) |=> status_word[BIT_C] == ($past(op_a) >= $past(op_b)));

  // R10: a direct write suppresses operation updates
  p_write_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_mask[3]) |=> $stable(status_word[W-1:24]));

endmodule

// File: tb/tb_cond_status_unit.sv
module tb_cond_status_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [1:0]  op_class = 2'd0;
  logic [31:0] op_a = '0, op_b = '0, op_res = '0;
  logic        set_flags = 1'b0, dest_is_pc = 1'b0, compare_only = 1'b0;
  logic        shift_carry_valid = 1'b0, shift_carry = 1'b0, sat_overflow = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_mask = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] status_word;
  logic        irq_enable, fiq_enable;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  cond_status_unit dut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_class(op_class),
    .op_a(op_a), .op_b(op_b), .op_res(op_res), .set_flags(set_flags),
    .dest_is_pc(dest_is_pc), .compare_only(compare_only),
    .shift_carry_valid(shift_carry_valid), .shift_carry(shift_carry),
    .sat_overflow(sat_overflow), .wr_en(wr_en), .wr_mask(wr_mask),
    .wr_data(wr_data), .status_word(status_word),
    .irq_enable(irq_enable), .fiq_enable(fiq_enable)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got=%h expected=%h", tag, got, exp);
    end
  endtask

  // Present an operation at a falling edge, sample one cycle later
  task automatic op(input logic [1:0] cls, input logic [31:0] a, input logic [31:0] b,
                    input logic [31:0] r, input logic sf, input logic pc, input logic cmp,
                    input logic scv, input logic sc, input logic sov);
    op_valid = 1'b1; op_class = cls; op_a = a; op_b = b; op_res = r;
    set_flags = sf; dest_is_pc = pc; compare_only = cmp;
    shift_carry_valid = scv; shift_carry = sc; sat_overflow = sov;
    @(negedge clk);
    op_valid = 1'b0;
  endtask

  task automatic wr(input logic [3:0] m, input logic [31:0] d);
    wr_en = 1'b1; wr_mask = m; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 reset word", status_word, 32'h0000_00D3);
    chk("R8 irq masked after reset", {31'd0, irq_enable}, 32'd0);
    chk("R8 fiq masked after reset", {31'd0, fiq_enable}, 32'd0);
  endtask

  task automatic t_unmask;
    wr(4'b0001, 32'h0000_0013);
    chk("R9 control byte write", status_word, 32'h0000_0013);
    chk("R8 irq enabled", {31'd0, irq_enable}, 32'd1);
    chk("R8 fiq enabled", {31'd0, fiq_enable}, 32'd1);
  endtask

  task automatic t_add;
    op(2'd0, 32'hFFFF_FFFF, 32'h1, 32'h0, 1, 0, 0, 0, 0, 0);
    chk("R2 R3 add wrap to zero", status_word, 32'h6000_0013);
    op(2'd0, 32'h7FFF_FFFF, 32'h1, 32'h8000_0000, 1, 0, 0, 0, 0, 0);
    chk("R2 R3 add signed overflow", status_word, 32'h9000_0013);
  endtask

  task automatic t_sub;
    op(2'd1, 32'd5, 32'd3, 32'd2, 1, 0, 0, 0, 0, 0);
    chk("R4 sub no borrow", status_word, 32'h2000_0013);
    op(2'd1, 32'd3, 32'd5, 32'hFFFF_FFFE, 1, 0, 0, 0, 0, 0);
    chk("R4 sub borrow", status_word, 32'h8000_0013);
    op(2'd1, 32'h8000_0000, 32'd1, 32'h7FFF_FFFF, 1, 0, 0, 0, 0, 0);
    chk("R4 sub signed overflow", status_word, 32'h3000_0013);
  endtask

  task automatic t_logic;
    op(2'd2, 32'h0, 32'h0, 32'h0, 1, 0, 0, 1, 0, 0);
    chk("R5 logic shifter carry", status_word, 32'h5000_0013);
    op(2'd2, 32'h0, 32'h0, 32'h8000_0000, 1, 0, 0, 0, 1, 0);
    chk("R5 logic keeps carry", status_word, 32'h9000_0013);
  endtask

  task automatic t_gating;
    op(2'd0, 32'hFFFF_FFFF, 32'h1, 32'h0, 1, 1, 0, 0, 0, 0);
    chk("R6 pc destination no update", status_word, 32'h9000_0013);
    op(2'd0, 32'hFFFF_FFFF, 32'h1, 32'h0, 0, 0, 0, 0, 0, 0);
    chk("R6 set_flags low no update", status_word, 32'h9000_0013);
    op(2'd1, 32'd7, 32'd7, 32'd0, 0, 1, 1, 0, 0, 0);
    chk("R6 compare updates", status_word, 32'h6000_0013);
    op(2'd3, 32'h0, 32'h0, 32'h1, 1, 0, 0, 0, 0, 0);
    chk("R6 saturating keeps flags", status_word, 32'h6000_0013);
  endtask

  task automatic t_sticky;
    op(2'd3, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 1, 0, 0, 0, 0, 1);
    chk("R7 Q set", status_word, 32'h6800_0013);
    op(2'd0, 32'd1, 32'd1, 32'd2, 1, 0, 0, 0, 0, 0);
    chk("R7 Q survives op", status_word, 32'h0800_0013);
    wr(4'b1000, 32'h0);
    chk("R7 Q cleared by write", status_word, 32'h0000_0013);
  endtask

  task automatic t_user;
    wr(4'b0001, 32'h0000_0010);
    chk("R9 enter user mode", status_word, 32'h0000_0010);
    wr(4'b0001, 32'h0000_00D3);
    chk("R9 control byte locked", status_word, 32'h0000_0010);
    chk("R8 irq still enabled", {31'd0, irq_enable}, 32'd1);
    wr(4'b1000, 32'hF000_0000);
    chk("R9 top byte writable in user", status_word, 32'hF000_0010);
  endtask

  task automatic t_collide;
    wr_en = 1'b1; wr_mask = 4'b0010; wr_data = 32'h0000_AB00;
    op(2'd0, 32'd1, 32'd1, 32'd2, 1, 0, 0, 0, 0, 0);
    wr_en = 1'b0;
    chk("R10 write wins over op", status_word, 32'hF000_AB10);
    wr_en = 1'b1; wr_mask = 4'b1000; wr_data = 32'h4000_0000;
    op(2'd3, 32'h0, 32'h0, 32'h0, 1, 0, 0, 0, 0, 1);
    wr_en = 1'b0;
    chk("R10 write wins over Q set", status_word, 32'h4000_AB10);
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_unmask();
    t_add();
    t_sub();
    t_logic();
    t_gating();
    t_sticky();
    t_user();
    t_collide();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule